// File: doc/BRIEF.md
# Instrument Status Reporting Unit

This block holds the status-reporting state of a measurement instrument in hardware. Two sticky event registers collect single-cycle pulses from the rest of the instrument, and each has its own enable mask:
- a standard event register, where a command error lands on bit 5;
- an internal state change register.

A status byte gathers summary bits from these sources. It also carries a latched value-adapted flag and the output-queue-not-empty level. A service request enable mask selects which status byte bits raise the service request line.

A host reaches the state through a small register port. It can:
- query a register, which returns the value and clears it;
- write the enable masks;
- clear all status with a single strobe;
- serial-poll the status byte.

Bit 6 of the status byte has two meanings:
- On a query it carries the master summary, which is computed live from the enabled bits.
- On a serial poll it carries a latched request-for-service flag. That flag is set when the master summary rises, and it is cleared only by the poll or by the clear strobe.

A saturating counter of command errors is also kept. Reading it returns its value and resets it in the same cycle.

Top module: `status_report_unit`

## Requirements
- R1: After reset every register reads zero, the service request output is low and no read data is flagged valid.
- R2: Each pulse on an event input, and a command error on bit 5, sets the matching bit of the event register until it is cleared. Reading selector 2 returns the event register, with bits 15:8 zero, and clears it. A pulse arriving in the same cycle as the clear leaves its bit set.
- R3: Internal state pulses set sticky bits in the internal state register. Reading selector 4 returns that register and clears it, and a pulse in the same cycle survives.
- R4: Status byte layout:
  - bit 0 = OR of (internal register AND its mask);
  - bit 2 = value-adapted flag, latched;
  - bit 4 = queue-not-empty level;
  - bit 5 = OR of (event register AND its mask);
  - bits 1, 3 and 7, and bits 15:8 of the read data, are zero.
- R5: Reading selector 0 returns the status byte with bit 6 equal to the master summary and clears the value-adapted flag. A value-adapted pulse in the same cycle keeps the flag set.
- R6: The master summary, and the service request output that follows it, is the OR of the status byte bits 0-5 and 7 that are enabled in the request mask. Mask bit 6 is ignored.
- R7: The request-for-service flag sets in the cycle after the master summary rises. Reading selector 1 (serial poll) returns the status byte with bit 6 equal to that flag, clears only the flag, and leaves the summary and its causes unchanged.
- R8: The clear-status strobe clears the event register, the value-adapted flag and the request-for-service flag. It leaves the enable masks untouched.
- R9: The masks are read/write: event mask at selector 3 (8 bits), internal mask at selector 5, request mask at selector 6 (8 bits). They reset to zero and read back what was written.
- R10: Each command error pulse increments a counter that saturates at all ones. Reading selector 7 returns the count and resets it, and an error in that same cycle leaves the count at 1.
- R11: Writes to selectors 0, 1, 2, 4 and 7 have no effect.
- R12: Read data is registered: `host_rvalid_o` is high exactly one cycle after `host_rd_i`, with `host_rdata_o` valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| host_rd_i | input | 1 | Read (query) strobe |
| host_wr_i | input | 1 | Write strobe |
| host_addr_i | input | 3 | Register selector |
| host_wdata_i | input | DATA_W | Write data |
| host_rdata_o | output | DATA_W | Read data, registered |
| host_rvalid_o | output | 1 | Read data valid |
| cls_i | input | 1 | Clear-status strobe |
| cmd_err_i | input | 1 | Command error pulse |
| esr_evt_i | input | 8 | Other event pulses into the event register |
| val_adj_i | input | 1 | Value-adapted pulse |
| int_evt_i | input | INR_W | Internal state change pulses |
| mav_i | input | 1 | Output queue not empty level |
| srq_o | output | 1 | Service request |

## Verification
The bench builds the block with a 16-bit data path and a 16-bit internal state register, so every mask bit and every read width is exercised. It narrows the command error counter to 4 bits, which brings saturation within reach after fifteen pulses and lets the counter hit its ceiling many times during random traffic. With these values, the same-cycle races between clears and events come up often in random traffic: query against pulse, poll against rising summary, and clear strobe against rising summary.

// File: rtl/srs_pkg.sv
// Shared selector encoding and status byte bit positions.
// Assumes an 8-bit status byte and a 3-bit register selector.
package srs_pkg;
    typedef enum logic [2:0] {
        SEL_STB  = 3'd0,
        SEL_POLL = 3'd1,
        SEL_ESR  = 3'd2,
        SEL_ESE  = 3'd3,
        SEL_INR  = 3'd4,
        SEL_INE  = 3'd5,
        SEL_SRE  = 3'd6,
        SEL_CMR  = 3'd7
    } reg_sel_e;

    localparam int STB_W       = 8;
    localparam int ESR_USED    = 8;
    localparam int STB_ISB     = 0;
    localparam int STB_VAB     = 2;
    localparam int STB_MAV     = 4;
    localparam int STB_ESB     = 5;
    localparam int STB_RQS     = 6;
    localparam int CMD_ERR_BIT = 5;
endpackage

// File: rtl/srs_sticky_reg.sv
// Sticky event register: pulses set bits, a clear empties it, and a set
// arriving with the clear wins. Also gives the masked OR summary.
module srs_sticky_reg #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] q_o,
    output logic         any_o
);
    // Hold event bits until cleared; new events override the clear.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) q_o <= '0;
        else         q_o <= (q_o & ~{W{clr_i}}) | set_i;
    end

    // Summary of the enabled bits.
    assign any_o = |(q_o & mask_i);
endmodule

// File: rtl/srs_err_counter.sv
// Saturating event counter with read-and-reset. An increment in the
// cycle of the reset leaves the count at one.
module srs_err_counter #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         inc_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    // Count, saturate, or restart on read.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                        cnt_o <= '0;
        else if (clr_i)                     cnt_o <= W'(inc_i);
        else if (inc_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/srs_service_req.sv
// Master summary and request-for-service flag. The summary is live.
// The flag latches when the summary rises and clears on poll or clear strobe.
module srs_service_req
    import srs_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [STB_W-1:0] stb_i,
    input  logic [STB_W-1:0] sre_i,
    input  logic             poll_clr_i,
    input  logic             cls_i,
    output logic             mss_o,
    output logic             rqs_o
);
    localparam logic [STB_W-1:0] SUM_MASK = ~(STB_W'(1) << STB_RQS);

    logic mss_d;

    // Summary over enabled bits, excluding the bit 6 position.
    assign mss_o = |(stb_i & sre_i & SUM_MASK);

    // Edge memory and request flag; a rising summary beats a clear.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            mss_d <= 1'b0;
            rqs_o <= 1'b0;
        end else begin
            mss_d <= mss_o;
            rqs_o <= (rqs_o & ~(poll_clr_i | cls_i)) | (mss_o & ~mss_d);
        end
    end
endmodule

// File: rtl/status_report_unit.sv
// Status reporting unit top: event and internal registers with masks,
// status byte, service request, error counter and a register port.
// Assumes single-cycle event pulses and no read and write in the same cycle.
module status_report_unit
    import srs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int INR_W  = 16,
    parameter int CMR_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              host_rd_i,
    input  logic              host_wr_i,
    input  logic [2:0]        host_addr_i,
    input  logic [DATA_W-1:0] host_wdata_i,
    output logic [DATA_W-1:0] host_rdata_o,
    output logic              host_rvalid_o,
    input  logic              cls_i,
    input  logic              cmd_err_i,
    input  logic [7:0]        esr_evt_i,
    input  logic              val_adj_i,
    input  logic [INR_W-1:0]  int_evt_i,
    input  logic              mav_i,
    output logic              srq_o
);
    reg_sel_e                sel;
    logic                    rd_stb, rd_poll, rd_esr, rd_inr, rd_cmr;
    logic [ESR_USED-1:0]     esr_set, esr_q, ese_q;
    logic [INR_W-1:0]        inr_q, ine_q;
    logic [STB_W-1:0]        sre_q, stb;
    logic [CMR_W-1:0]        cmr_q;
    logic                    esb, isb, vab_q, mss, rqs;
    logic [DATA_W-1:0]       rd_mux;

    assign sel     = reg_sel_e'(host_addr_i);
    assign rd_stb  = host_rd_i && sel == SEL_STB;
    assign rd_poll = host_rd_i && sel == SEL_POLL;
    assign rd_esr  = host_rd_i && sel == SEL_ESR;
    assign rd_inr  = host_rd_i && sel == SEL_INR;
    assign rd_cmr  = host_rd_i && sel == SEL_CMR;

    // Command error joins the other event pulses at its fixed bit.
    always_comb begin
        esr_set = esr_evt_i;
        esr_set[CMD_ERR_BIT] = esr_evt_i[CMD_ERR_BIT] | cmd_err_i;
    end

    srs_sticky_reg #(.W(ESR_USED)) u_esr (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(esr_set), .clr_i(cls_i | rd_esr),
        .mask_i(ese_q), .q_o(esr_q), .any_o(esb));

    srs_sticky_reg #(.W(INR_W)) u_inr (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(int_evt_i), .clr_i(rd_inr),
        .mask_i(ine_q), .q_o(inr_q), .any_o(isb));

    // Value-adapted flag: latched, cleared by status byte query or clear strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) vab_q <= 1'b0;
        else         vab_q <= (vab_q & ~(cls_i | rd_stb)) | val_adj_i;
    end

    // Enable masks, written only through their own selectors.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ese_q <= '0;
            ine_q <= '0;
            sre_q <= '0;
        end else if (host_wr_i) begin
            if (sel == SEL_ESE) ese_q <= host_wdata_i[ESR_USED-1:0];
            if (sel == SEL_INE) ine_q <= host_wdata_i[INR_W-1:0];
            if (sel == SEL_SRE) sre_q <= host_wdata_i[STB_W-1:0];
        end
    end

    // Status byte assembly; bit 6 is filled per read type.
    always_comb begin
        stb          = '0;
        stb[STB_ISB] = isb;
        stb[STB_VAB] = vab_q;
        stb[STB_MAV] = mav_i;
        stb[STB_ESB] = esb;
    end

    srs_service_req u_srq (
        .clk_i(clk_i), .rst_ni(rst_ni), .stb_i(stb), .sre_i(sre_q),
        .poll_clr_i(rd_poll), .cls_i(cls_i), .mss_o(mss), .rqs_o(rqs));

    assign srq_o = mss;

    srs_err_counter #(.W(CMR_W)) u_cmr (
        .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(cmd_err_i), .clr_i(rd_cmr),
        .cnt_o(cmr_q));

    // Read data selection.
    always_comb begin
        case (sel)
            SEL_STB:  rd_mux = DATA_W'(stb) | (DATA_W'(mss) << STB_RQS);
            SEL_POLL: rd_mux = DATA_W'(stb) | (DATA_W'(rqs) << STB_RQS);
            SEL_ESR:  rd_mux = DATA_W'(esr_q);
            SEL_ESE:  rd_mux = DATA_W'(ese_q);
            SEL_INR:  rd_mux = DATA_W'(inr_q);
            SEL_INE:  rd_mux = DATA_W'(ine_q);
            SEL_SRE:  rd_mux = DATA_W'(sre_q);
            SEL_CMR:  rd_mux = DATA_W'(cmr_q);
            default:  rd_mux = '0;
        endcase
    end

    // Registered read return.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            host_rdata_o  <= '0;
            host_rvalid_o <= 1'b0;
        end else begin
            host_rvalid_o <= host_rd_i;
            if (host_rd_i) host_rdata_o <= rd_mux;
        end
    end
endmodule

// File: rtl/srs_checker.sv
// Temporal checks on the status reporting unit, bound to its top module.
module srs_checker #(
    parameter int DATA_W = 16,
    parameter int CMR_W  = 8
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              host_rd_i,
    input logic              host_wr_i,
    input logic [2:0]        host_addr_i,
    input logic [DATA_W-1:0] host_rdata_o,
    input logic              host_rvalid_o,
    input logic              cls_i,
    input logic              cmd_err_i,
    input logic              mav_i,
    input logic              srq_o,
    input logic [7:0]        esr_q,
    input logic [7:0]        ese_q,
    input logic [7:0]        sre_q,
    input logic              mss,
    input logic              rqs,
    input logic [CMR_W-1:0]  cmr_q
);
    localparam logic [CMR_W-1:0] CMR_MAX = {CMR_W{1'b1}};

    p_rvalid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (host_rvalid_o == $past(host_rd_i)));

    p_cmd_err_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(cmd_err_i)) |-> esr_q[5]);

    p_stb_unused_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_rvalid_o && $past(host_addr_i) <= 3'd1) |->
        (!host_rdata_o[7] && !host_rdata_o[3] && !host_rdata_o[1] &&
         host_rdata_o[DATA_W-1:8] == '0));

    p_mav_requests_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mav_i && sre_q[4]) |-> srq_o);

    p_rqs_on_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $rose(rqs)) |-> $past(mss));

    p_cls_masks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(cls_i) && !$past(host_wr_i)) |->
        ($stable(ese_q) && $stable(sre_q)));

    p_cmr_sat_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(cmr_q) == CMR_MAX &&
         !($past(host_rd_i) && $past(host_addr_i) == 3'd7)) |-> cmr_q == CMR_MAX);
endmodule

bind status_report_unit srs_checker #(.DATA_W(DATA_W), .CMR_W(CMR_W)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .host_rd_i(host_rd_i), .host_wr_i(host_wr_i),
    .host_addr_i(host_addr_i), .host_rdata_o(host_rdata_o),
    .host_rvalid_o(host_rvalid_o), .cls_i(cls_i), .cmd_err_i(cmd_err_i),
    .mav_i(mav_i), .srq_o(srq_o), .esr_q(esr_q), .ese_q(ese_q), .sre_q(sre_q),
    .mss(mss), .rqs(rqs), .cmr_q(cmr_q));

// File: tb/status_report_unit_tb.sv
// Bench: directed corners plus seeded random traffic, checked against a
// cycle model written from the requirements.
module status_report_unit_tb;
    localparam int DATA_W = 16;
    localparam int INR_W  = 16;
    localparam int CMR_W  = 4;
    localparam logic [CMR_W-1:0] CMAX = {CMR_W{1'b1}};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd = 1'b0, wr = 1'b0, cls = 1'b0, cmd = 1'b0, va = 1'b0, mav = 1'b0;
    logic [2:0]        addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [7:0]        ev = '0;
    logic [INR_W-1:0]  ie = '0;
    logic [DATA_W-1:0] rdata;
    logic              rvalid, srq;

    status_report_unit #(.DATA_W(DATA_W), .INR_W(INR_W), .CMR_W(CMR_W)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .host_rd_i(rd), .host_wr_i(wr),
        .host_addr_i(addr), .host_wdata_i(wdata), .host_rdata_o(rdata),
        .host_rvalid_o(rvalid), .cls_i(cls), .cmd_err_i(cmd), .esr_evt_i(ev),
        .val_adj_i(va), .int_evt_i(ie), .mav_i(mav), .srq_o(srq));

    always #2 clk = ~clk;

    // Model state.
    logic [7:0]        m_esr = '0, m_ese = '0, m_sre = '0;
    logic [INR_W-1:0]  m_inr = '0, m_ine = '0;
    logic              m_vab = 1'b0, m_rqs = 1'b0, m_mss_d = 1'b0;
    logic [CMR_W-1:0]  m_cmr = '0;
    logic              exp_valid = 1'b0, exp_srq = 1'b0, armed = 1'b0, done = 1'b0;
    logic [DATA_W-1:0] exp_rdata = '0;
    string             exp_tag = "", ctx = "";
    int                n_vec = 0, n_fail = 0;

    function automatic logic [7:0] f_stb(input logic mv);
        logic [7:0] s = '0;
        s[0] = |(m_inr & m_ine);
        s[2] = m_vab;
        s[4] = mv;
        s[5] = |(m_esr & m_ese);
        return s;
    endfunction

    function automatic logic f_mss(input logic [7:0] s);
        return |(s & m_sre & 8'hBF);
    endfunction

    function automatic string addr_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R5";
            3'd1: return "R7";
            3'd2: return "R2";
            3'd4: return "R3";
            3'd7: return "R10";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: check last cycle's results, drive new inputs, advance the model.
    task automatic tick(input logic i_rd, input logic i_wr, input logic [2:0] i_a,
                        input logic [DATA_W-1:0] i_wd, input logic i_cls, input logic i_cmd,
                        input logic [7:0] i_ev, input logic i_va,
                        input logic [INR_W-1:0] i_ie, input logic i_mav);
        logic [7:0] s;
        logic       ms;
        @(negedge clk);
        if (armed) begin
            chk((ctx != "") ? ctx : "R12", DATA_W'(rvalid), DATA_W'(exp_valid));
            if (exp_valid) chk(exp_tag, rdata, exp_rdata);
            chk((ctx != "") ? ctx : "R6", DATA_W'(srq), DATA_W'(exp_srq));
        end
        rd = i_rd; wr = i_wr; addr = i_a; wdata = i_wd; cls = i_cls; cmd = i_cmd;
        ev = i_ev; va = i_va; ie = i_ie; mav = i_mav;
        s  = f_stb(i_mav);
        ms = f_mss(s);
        exp_valid = i_rd;
        if (i_rd) begin
            exp_tag = (ctx != "") ? ctx : addr_tag(i_a);
            case (i_a)
                3'd0: exp_rdata = DATA_W'(s) | (DATA_W'(ms) << 6);
                3'd1: exp_rdata = DATA_W'(s) | (DATA_W'(m_rqs) << 6);
                3'd2: exp_rdata = DATA_W'(m_esr);
                3'd3: exp_rdata = DATA_W'(m_ese);
                3'd4: exp_rdata = DATA_W'(m_inr);
                3'd5: exp_rdata = DATA_W'(m_ine);
                3'd6: exp_rdata = DATA_W'(m_sre);
                default: exp_rdata = DATA_W'(m_cmr);
            endcase
        end
        m_rqs   = (m_rqs & ~(i_cls | (i_rd && i_a == 3'd1))) | (ms & ~m_mss_d);
        m_mss_d = ms;
        m_esr   = (m_esr & ~{8{i_cls | (i_rd && i_a == 3'd2)}}) | i_ev | (8'(i_cmd) << 5);
        m_inr   = (m_inr & ~{INR_W{i_rd && i_a == 3'd4}}) | i_ie;
        m_vab   = (m_vab & ~(i_cls | (i_rd && i_a == 3'd0))) | i_va;
        if (i_rd && i_a == 3'd7) m_cmr = CMR_W'(i_cmd);
        else if (i_cmd && m_cmr != CMAX) m_cmr = m_cmr + 1'b1;
        if (i_wr && i_a == 3'd3) m_ese = i_wd[7:0];
        if (i_wr && i_a == 3'd5) m_ine = i_wd[INR_W-1:0];
        if (i_wr && i_a == 3'd6) m_sre = i_wd[7:0];
        exp_srq = f_mss(f_stb(i_mav));
    endtask

    task automatic idle();
        tick(0, 0, 3'd0, '0, 0, 0, '0, 0, '0, mav);
    endtask
    task automatic rd_reg(input logic [2:0] a);
        tick(1, 0, a, '0, 0, 0, '0, 0, '0, mav);
    endtask
    task automatic wr_reg(input logic [2:0] a, input logic [DATA_W-1:0] d);
        tick(0, 1, a, d, 0, 0, '0, 0, '0, mav);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20461));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        armed = 1'b1;

        // R1: all registers zero after reset.
        ctx = "R1";
        for (int a = 0; a < 8; a++) rd_reg(3'(a));
        idle();

        // R9: masks read back.
        ctx = "R9";
        wr_reg(3'd3, 16'hFF20); wr_reg(3'd5, 16'h8001); wr_reg(3'd6, 16'h0035);
        rd_reg(3'd3); rd_reg(3'd5); rd_reg(3'd6); idle();

        // R4: status byte layout with all sources active.
        ctx = "R4";
        tick(0, 0, 3'd0, '0, 0, 1, '0, 1, 16'h8000, 1);
        idle(); rd_reg(3'd1); idle();

        // R7: poll clears only the request flag.
        ctx = "R7";
        rd_reg(3'd1); rd_reg(3'd1); idle();

        // R5: query shows summary, clears value-adapted flag.
        ctx = "R5";
        rd_reg(3'd0); rd_reg(3'd0); idle();

        // R2: command error during event register read stays set.
        ctx = "R2";
        tick(1, 0, 3'd2, '0, 0, 1, 8'h01, 0, '0, mav);
        rd_reg(3'd2); rd_reg(3'd2); idle();

        // R8: clear strobe keeps masks.
        ctx = "R8";
        tick(0, 0, 3'd0, '0, 1, 0, '0, 0, '0, mav);
        rd_reg(3'd2); rd_reg(3'd3); rd_reg(3'd6); rd_reg(3'd1); idle();

        // R11: writes to read-only selectors ignored.
        ctx = "R11";
        foreach (wr_ro[i]) wr_reg(wr_ro[i], 16'hFFFF);
        rd_reg(3'd0); rd_reg(3'd2); rd_reg(3'd4); rd_reg(3'd7); idle();

        // R10: saturation and read-with-error.
        ctx = "R10";
        rd_reg(3'd7);
        repeat (20) tick(0, 0, 3'd0, '0, 0, 1, '0, 0, '0, mav);
        rd_reg(3'd7);
        tick(1, 0, 3'd7, '0, 0, 1, '0, 0, '0, mav);
        rd_reg(3'd7); idle();

        // R3: internal register race with read.
        ctx = "R3";
        tick(0, 0, 3'd0, '0, 0, 0, '0, 0, 16'h0003, mav);
        tick(1, 0, 3'd4, '0, 0, 0, '0, 0, 16'h0100, mav);
        rd_reg(3'd4); idle();

        // Random traffic.
        ctx = "";
        for (int n = 0; n < 3000; n++) begin
            logic          r_rd, r_wr;
            logic [7:0]    r_ev;
            logic [INR_W-1:0] r_ie;
            logic          r_mav;
            r_rd  = ($urandom % 4) == 0;
            r_wr  = !r_rd && ($urandom % 8) == 0;
            r_ev  = (($urandom % 12) == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
            r_ie  = (($urandom % 12) == 0) ? INR_W'(1 << ($urandom % INR_W)) : '0;
            r_mav = (($urandom % 20) == 0) ? ~mav : mav;
            tick(r_rd, r_wr, 3'($urandom % 8), DATA_W'($urandom),
                 ($urandom % 40) == 0, ($urandom % 10) == 0, r_ev,
                 ($urandom % 12) == 0, r_ie, r_mav);
        end
        idle(); idle();
        finish_run();
    end

    logic [2:0] wr_ro [5] = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd7};
endmodule